// File: doc/BRIEF.md
# Separable Shading Correction and Bayer Colour Gain

This block sits in a raw pixel stream, ahead of any tone curve. It multiplies each 12-bit pixel by a position-dependent shading factor F(x,y) and then by one of four gain values, chosen by the pixel's place in the 2x2 Bayer tile. F is the sum of a horizontal quadratic term and a vertical quadratic term. Each term is produced by a pair of running-difference accumulators, so the surface needs no multiplier. One F serves all four colours.

Software programs each axis with three signed values: the term's value at position 0, its first difference there, and its constant second difference. The optical centre and the curvature are folded into these three values. A value of 0x8000 in F stands for unity, so F can reach about x4. The gain stage shifts right by 15 or 16 bits. Shifting by 16 makes 0x10000 the unity gain, which gives one more bit of precision over a 2:1 range. F and the output both clamp at their maximum and never wrap.

Top module: `shade_gain_corr`

## Requirements
- R1: After reset, out_valid, out_sol and out_sof are 0. out_pix is 0 on every cycle where out_valid is low.
- R2: On a valid pixel with in_sol or in_sof high, the horizontal term is x_start. On the n-th later valid pixel of that line it is x_start + n*x_slope + x_curv*n*(n-1)/2.
- R3: On a valid pixel with in_sof high, the vertical term is y_start. On the m-th later line start of that frame it is y_start + m*y_slope + y_curv*m*(m-1)/2, and it is held for the whole line.
- R4: F is the sum of the two terms, limited to the range 0 to 0x1FFFF. The intermediate value v1 = (pix*F + 0x4000) >> 15. The same F is used whatever the colour.
- R5: Where the sum of the terms is above 0x1FFFF, F is exactly 0x1FFFF and does not wrap.
- R6: The gain is taken from gains[17*k+16:17*k], with k = 2*row_parity + col_parity. The row and column counts are 0 at a frame start and at a line start.
- R7: out_pix = min(4095, (v1*G + 2^(S-1)) >> S), with S = 15 when gain_shift is 0 and S = 16 when gain_shift is 1.
- R8: Each valid input comes out exactly 3 cycles later. out_sol and out_sof equal in_sol&in_valid and in_sof&in_valid, delayed by the same 3 cycles.
- R9: Cycles with in_valid low, whatever their markers or data, do not move either term or the colour parity, and give no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame (also starts a line) |
| in_pix | input | 12 | Raw pixel |
| x_start | input | 24 | Horizontal term at column 0 (signed) |
| x_slope | input | 24 | Horizontal first difference at column 0 (signed) |
| x_curv | input | 24 | Horizontal second difference (signed) |
| y_start | input | 24 | Vertical term at row 0 (signed) |
| y_slope | input | 24 | Vertical first difference at row 0 (signed) |
| y_curv | input | 24 | Vertical second difference (signed) |
| gains | input | 68 | Four 17-bit colour gains, index k at bits 17k+16:17k |
| gain_shift | input | 1 | 0: gain unity 0x8000; 1: gain unity 0x10000 |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Delayed line-start marker |
| out_sof | output | 1 | Delayed frame-start marker |
| out_pix | output | 12 | Corrected pixel |

## Verification
Each pixel presented before a rising edge produces its corrected value and markers three rising edges later. The bench drives inputs just after a rising edge and samples on falling edges. On every falling edge it records the expected result for the current input in a three-entry queue, and it compares the outputs against the entry recorded three falling edges earlier. The expected values come from closed-form sums of the two quadratic terms, which the bench evaluates from its own line and frame counters. Saturation, the negative clamp, the two shift settings and invalid cycles carrying stray markers each get a directed scenario.

// File: rtl/shade_pkg.sv
package shade_pkg;

  typedef struct packed {
    logic valid;
    logic sol;
    logic sof;
  } shade_mark_t;

  // rounded right shift (round half up)
  function automatic logic [63:0] rnd_shr(input logic [63:0] v, input int unsigned sh);
    logic [63:0] half;
    half = 64'd1 << (sh - 1);
    return (v + half) >> sh;
  endfunction

  // upper clamp of an unsigned value
  function automatic logic [63:0] sat_hi(input logic [63:0] v, input logic [63:0] hi);
    return (v > hi) ? hi : v;
  endfunction

endpackage

// File: rtl/shade_axis_acc.sv
module shade_axis_acc #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                step,
  input  logic signed [W-1:0] start,
  input  logic signed [W-1:0] slope,
  input  logic signed [W-1:0] curv,
  output logic signed [W-1:0] cur
);

  logic signed [W-1:0] val_q, dx_q;
  logic signed [W-1:0] adv;

  assign adv = val_q + dx_q;

  always_comb begin
    if (restart)   cur = start;
    else if (step) cur = adv;
    else           cur = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dx_q  <= '0;
    end else if (restart) begin
      val_q <= start;
      dx_q  <= slope;
    end else if (step) begin
      val_q <= adv;
      dx_q  <= dx_q + curv;
    end
  end

  // R2 / R3: a restart loads the programmed start value and slope
  a_r2_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (val_q == $past(start)) && (dx_q == $past(slope)));

  // R9: without a restart or a step the accumulator holds its state
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !step) |=> ($stable(val_q) && $stable(dx_q)));

endmodule

// File: rtl/shade_apply.sv
module shade_apply #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 17,
  parameter int ONE_SH = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  shade_pkg::shade_mark_t    in_mark,
  input  logic [PIX_W-1:0]          in_pix,
  input  logic [COEF_W-1:0]         in_f,
  input  logic [COEF_W-1:0]         in_gain,
  input  logic                      in_shift,
  output shade_pkg::shade_mark_t    out_mark,
  output logic [PIX_W-1:0]          out_pix
);

  localparam int V_W  = PIX_W + 3;
  localparam int P1_W = PIX_W + COEF_W;
  localparam int P2_W = V_W + COEF_W;
  localparam logic [63:0] PIX_MAX = 64'((1 << PIX_W) - 1);

  // stage 2: pixel times shading factor
  logic [P1_W-1:0]        prod1;
  logic [V_W-1:0]         v1_n;
  shade_pkg::shade_mark_t s2_mark;
  logic [V_W-1:0]         s2_v1;
  logic [COEF_W-1:0]      s2_gain;
  logic                   s2_shift;

  assign prod1 = P1_W'(in_pix) * P1_W'(in_f);
  assign v1_n  = V_W'(shade_pkg::rnd_shr(64'(prod1), ONE_SH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_mark  <= '0;
      s2_v1    <= '0;
      s2_gain  <= '0;
      s2_shift <= 1'b0;
    end else begin
      s2_mark  <= in_mark;
      s2_v1    <= v1_n;
      s2_gain  <= in_gain;
      s2_shift <= in_shift;
    end
  end

  // stage 3: colour gain, selectable shift, saturation
  logic [P2_W-1:0]   prod2;
  int unsigned       g_sh;
  logic [63:0]       g_rnd;
  logic [PIX_W-1:0]  res_n;

  assign prod2 = P2_W'(s2_v1) * P2_W'(s2_gain);
  assign g_sh  = s2_shift ? ONE_SH + 1 : ONE_SH;
  assign g_rnd = shade_pkg::rnd_shr(64'(prod2), g_sh);
  assign res_n = PIX_W'(shade_pkg::sat_hi(g_rnd, PIX_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mark <= '0;
      out_pix  <= '0;
    end else begin
      out_mark <= s2_mark;
      out_pix  <= s2_mark.valid ? res_n : '0;
    end
  end

  // R1: no pixel value leaves without its qualifier
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mark.valid |-> (out_pix == '0));

endmodule

// File: rtl/shade_gain_corr.sv
module shade_gain_corr #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 17,
  parameter int ACC_W  = 24,
  parameter int ONE_SH = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_sol,
  input  logic                       in_sof,
  input  logic [PIX_W-1:0]           in_pix,
  input  logic signed [ACC_W-1:0]    x_start,
  input  logic signed [ACC_W-1:0]    x_slope,
  input  logic signed [ACC_W-1:0]    x_curv,
  input  logic signed [ACC_W-1:0]    y_start,
  input  logic signed [ACC_W-1:0]    y_slope,
  input  logic signed [ACC_W-1:0]    y_curv,
  input  logic [4*COEF_W-1:0]        gains,
  input  logic                       gain_shift,
  output logic                       out_valid,
  output logic                       out_sol,
  output logic                       out_sof,
  output logic [PIX_W-1:0]           out_pix
);

  localparam int N_AXIS  = 2;
  localparam int N_COLOR = 4;
  localparam logic [ACC_W-1:0] F_MAX = ACC_W'((1 << COEF_W) - 1);

  // line / frame events
  logic line_go, frame_go;
  assign line_go  = in_valid & (in_sol | in_sof);
  assign frame_go = in_valid & in_sof;

  // axis accumulators: 0 = horizontal, 1 = vertical
  logic                    ax_restart [N_AXIS];
  logic                    ax_step    [N_AXIS];
  logic signed [ACC_W-1:0] ax_start   [N_AXIS];
  logic signed [ACC_W-1:0] ax_slope   [N_AXIS];
  logic signed [ACC_W-1:0] ax_curv    [N_AXIS];
  logic signed [ACC_W-1:0] ax_cur     [N_AXIS];

  assign ax_restart[0] = line_go;
  assign ax_step[0]    = in_valid & ~line_go;
  assign ax_start[0]   = x_start;
  assign ax_slope[0]   = x_slope;
  assign ax_curv[0]    = x_curv;
  assign ax_restart[1] = frame_go;
  assign ax_step[1]    = line_go & ~frame_go;
  assign ax_start[1]   = y_start;
  assign ax_slope[1]   = y_slope;
  assign ax_curv[1]    = y_curv;

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    shade_axis_acc #(.W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ax_restart[a]),
      .step    (ax_step[a]),
      .start   (ax_start[a]),
      .slope   (ax_slope[a]),
      .curv    (ax_curv[a]),
      .cur     (ax_cur[a])
    );
  end

  // shading factor with clamping on both sides
  logic signed [ACC_W:0] f_sum;
  logic                  f_over, f_under;
  logic [COEF_W-1:0]     f_now;

  assign f_sum   = {ax_cur[0][ACC_W-1], ax_cur[0]} + {ax_cur[1][ACC_W-1], ax_cur[1]};
  assign f_under = f_sum[ACC_W];
  assign f_over  = !f_sum[ACC_W] && (f_sum[ACC_W-1:0] > F_MAX);
  assign f_now   = f_under ? '0 : (f_over ? F_MAX[COEF_W-1:0] : f_sum[COEF_W-1:0]);

  // Bayer parity
  logic col_q, row_q, col_now, row_now;
  assign col_now = line_go ? 1'b0 : ~col_q;
  assign row_now = frame_go ? 1'b0 : (line_go ? ~row_q : row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= 1'b0;
      row_q <= 1'b0;
    end else if (in_valid) begin
      col_q <= col_now;
      row_q <= row_now;
    end
  end

  logic [COEF_W-1:0] gain_arr [N_COLOR];
  for (genvar c = 0; c < N_COLOR; c++) begin : g_gain
    assign gain_arr[c] = gains[c*COEF_W +: COEF_W];
  end

  logic [1:0] color_now;
  assign color_now = {row_now, col_now};

  // stage 1 register
  shade_pkg::shade_mark_t s1_mark;
  logic [PIX_W-1:0]       s1_pix;
  logic [COEF_W-1:0]      s1_f;
  logic [COEF_W-1:0]      s1_gain;
  logic                   s1_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_mark  <= '0;
      s1_pix   <= '0;
      s1_f     <= '0;
      s1_gain  <= '0;
      s1_shift <= 1'b0;
    end else begin
      s1_mark  <= '{valid: in_valid, sol: in_valid & in_sol, sof: in_valid & in_sof};
      s1_pix   <= in_pix;
      s1_f     <= f_now;
      s1_gain  <= gain_arr[color_now];
      s1_shift <= gain_shift;
    end
  end

  shade_pkg::shade_mark_t o_mark;

  shade_apply #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ONE_SH(ONE_SH)) u_apply (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_mark  (s1_mark),
    .in_pix   (s1_pix),
    .in_f     (s1_f),
    .in_gain  (s1_gain),
    .in_shift (s1_shift),
    .out_mark (o_mark),
    .out_pix  (out_pix)
  );

  assign out_valid = o_mark.valid;
  assign out_sol   = o_mark.sol;
  assign out_sof   = o_mark.sof;

  // R5: an oversized sum of terms is registered as the maximum factor
  a_r5_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_over) |=> (s1_f == F_MAX[COEF_W-1:0]));

  // R8: fixed three-cycle latency of the qualifier
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R9: invalid input never produces output
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

endmodule

// File: tb/shade_gain_corr_tb.sv
`timescale 1ns/1ps
module shade_gain_corr_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic in_valid, in_sol, in_sof, gain_shift;
  logic [11:0] in_pix;
  logic signed [23:0] x_start, x_slope, x_curv, y_start, y_slope, y_curv;
  logic [16:0] g [4];
  logic [67:0] gains;
  logic out_valid, out_sol, out_sof;
  logic [11:0] out_pix;

  assign gains = {g[3], g[2], g[1], g[0]};

  shade_gain_corr u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
    .in_pix(in_pix), .x_start(x_start), .x_slope(x_slope), .x_curv(x_curv),
    .y_start(y_start), .y_slope(y_slope), .y_curv(y_curv), .gains(gains),
    .gain_shift(gain_shift), .out_valid(out_valid), .out_sol(out_sol),
    .out_sof(out_sof), .out_pix(out_pix)
  );

  int checks = 0;
  int errors = 0;
  bit mon_en = 0;
  string cur_tag = "R4";

  // expectation queue, entry 2 is three falling edges old
  logic  pv [3];
  logic  ps [3];
  logic  pf [3];
  int    pe [3];
  string pt [3];

  longint bx = 0, by = 0;

  function automatic longint term(longint s, longint d, longint c, longint n);
    return s + n * d + c * ((n * (n - 1)) / 2);
  endfunction

  function automatic int expect_pix(longint pix, longint col, longint row);
    longint f, v1, gg, sh, r;
    f = term(longint'(x_start), longint'(x_slope), longint'(x_curv), col)
      + term(longint'(y_start), longint'(y_slope), longint'(y_curv), row);
    if (f < 0) f = 0;
    if (f > 131071) f = 131071;
    v1 = (pix * f + 16384) / 32768;
    gg = longint'(g[int'(((row % 2) * 2) + (col % 2))]);
    sh = gain_shift ? 65536 : 32768;
    r  = (v1 * gg + sh / 2) / sh;
    if (r > 4095) r = 4095;
    return int'(r);
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      if (pv[2] || out_valid) begin
        checks++;
        if (out_valid !== pv[2] || out_sol !== ps[2] || out_sof !== pf[2]) begin
          errors++;
          $display("FAIL R8 markers: got v%0b l%0b f%0b expected v%0b l%0b f%0b",
                   out_valid, out_sol, out_sof, pv[2], ps[2], pf[2]);
        end else if (int'(out_pix) != pe[2]) begin
          errors++;
          $display("FAIL %s pixel: got %0d expected %0d", pt[2], out_pix, pe[2]);
        end
      end
      for (int i = 2; i > 0; i--) begin
        pv[i] = pv[i-1]; ps[i] = ps[i-1]; pf[i] = pf[i-1]; pe[i] = pe[i-1]; pt[i] = pt[i-1];
      end
      pv[0] = in_valid;
      ps[0] = in_valid & in_sol;
      pf[0] = in_valid & in_sof;
      pt[0] = cur_tag;
      pe[0] = 0;
      if (in_valid) begin
        if (in_sof) by = 0; else if (in_sol) by = by + 1;
        if (in_sol || in_sof) bx = 0; else bx = bx + 1;
        pe[0] = expect_pix(longint'(in_pix), bx, by);
      end
    end
  end

  task automatic drive(input logic v, input logic l, input logic f, input int p);
    @(posedge clk); #1;
    in_valid = v; in_sol = l; in_sof = f; in_pix = 12'(p);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic send_frame(input int lines, input int width, input int seed);
    for (int r = 0; r < lines; r++)
      for (int c = 0; c < width; c++)
        drive(1'b1, c == 0, (r == 0) && (c == 0), (seed + r * 517 + c * 263) % 4096);
    idle(5);
  endtask

  task automatic set_axes(input int xs, input int xd, input int xc,
                          input int ys, input int yd, input int yc);
    x_start = 24'(xs); x_slope = 24'(xd); x_curv = 24'(xc);
    y_start = 24'(ys); y_slope = 24'(yd); y_curv = 24'(yc);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 0; in_sol = 0; in_sof = 0; in_pix = 0; gain_shift = 0;
    set_axes(0, 0, 0, 32768, 0, 0);
    for (int i = 0; i < 4; i++) g[i] = 17'h08000;
    for (int i = 0; i < 3; i++) begin pv[i] = 0; ps[i] = 0; pf[i] = 0; pe[i] = 0; pt[i] = "R8"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sol !== 1'b0 || out_sof !== 1'b0 || out_pix !== 12'd0) begin
      errors++;
      $display("FAIL R1 reset: got v%0b l%0b f%0b pix %0d expected all 0",
               out_valid, out_sol, out_sof, out_pix);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk); mon_en = 1;
  endtask

  task automatic t_unity;        // R4 R7 with unity factor and gain
    cur_tag = "R4";
    send_frame(2, 6, 11);
  endtask

  task automatic t_xquad;        // R2
    cur_tag = "R2";
    set_axes(4096, -768, 256, 28672, 0, 0);
    send_frame(2, 8, 1234);
  endtask

  task automatic t_yquad;        // R3
    cur_tag = "R3";
    set_axes(0, 0, 0, 20000, 3000, -400);
    send_frame(5, 3, 3000);
  endtask

  task automatic t_colors;       // R6
    cur_tag = "R6";
    set_axes(0, 0, 0, 32768, 0, 0);
    g[0] = 17'h04000; g[1] = 17'h08000; g[2] = 17'h0C000; g[3] = 17'h10000;
    send_frame(4, 4, 2000);
  endtask

  task automatic t_shift;        // R7
    cur_tag = "R7";
    gain_shift = 1;
    g[0] = 17'h10000; g[1] = 17'h18000; g[2] = 17'h0A000; g[3] = 17'h1FFFF;
    send_frame(2, 5, 777);
    gain_shift = 0;
    for (int i = 0; i < 4; i++) g[i] = 17'h08000;
  endtask

  task automatic t_sat;          // R5 and R7 saturation, R4 low clamp
    cur_tag = "R5";
    set_axes(0, 2048, 4096, 126976, 0, 0);
    send_frame(1, 8, 1500);
    cur_tag = "R7";
    for (int i = 0; i < 4; i++) g[i] = 17'h1FFFF;
    drive(1'b1, 1'b1, 1'b1, 4095);
    drive(1'b1, 1'b0, 1'b0, 4095);
    idle(5);
    cur_tag = "R4";
    set_axes(-5000, 0, 0, 3000, 0, 0);
    send_frame(1, 4, 4000);
    for (int i = 0; i < 4; i++) g[i] = 17'h08000;
  endtask

  task automatic t_gaps;         // R9
    cur_tag = "R9";
    set_axes(8192, 1000, 200, 16384, 2000, 100);
    g[0] = 17'h06000; g[1] = 17'h0A000; g[2] = 17'h0E000; g[3] = 17'h12000;
    drive(1'b1, 1'b1, 1'b1, 1000);
    drive(1'b0, 1'b1, 1'b1, 4095);
    drive(1'b1, 1'b0, 1'b0, 1100);
    drive(1'b0, 1'b1, 1'b0, 4000);
    drive(1'b0, 1'b0, 1'b1, 3000);
    drive(1'b1, 1'b0, 1'b0, 1200);
    drive(1'b1, 1'b1, 1'b0, 1300);
    drive(1'b0, 1'b1, 1'b0, 50);
    drive(1'b1, 1'b0, 1'b0, 1400);
    drive(1'b1, 1'b1, 1'b0, 1500);
    drive(1'b1, 1'b0, 1'b0, 1600);
    idle(5);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unity();
    t_xquad();
    t_yquad();
    t_colors();
    t_shift();
    t_sat();
    t_gaps();
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule